// File: doc/BRIEF.md
# Charge Pump Mode and Protection Supervisor

This block is the digital supervisor for a fractional charge pump that powers a group of LED current sinks. It reads comparator flags from the analog side: a per-sink "headroom low" flag, a per-sink "headroom recovered" flag, a per-sink open-circuit flag, and global over-voltage and over-temperature flags. It also reads the software sink-enable bits and a write strobe for them. From these it chooses the pump multiplier (1x, 1.5x or 2x) and gates the pump clock. It enters sleep when software enables no sink. It masks sinks that have faulted or are affected by a global fault.

The multiplier rises one step when any sink that is on reports low headroom. It falls one step only when every sink that is on reports a separate "recovered" condition. This gap between the two thresholds is the hysteresis. After each change the mode is held for a minimum dwell, which debounces the comparators. A sink that reports an open circuit while enabled is latched off on its own. Over-temperature blanks every output but keeps all internal state. Driving the enable pin low resets everything asynchronously.

Every output is a register. Inputs sampled at a rising clock edge take effect on the outputs right after that same edge. The clock is the pump clock itself, so a dwell counted in clock cycles is a dwell in pump periods.

Top module: `cp_supervisor`

## Requirements
- R1: `mode_o` encodes 0 = 1x, 1 = 1.5x, 2 = 2x and never shows 3. When any sink that is on (`sink_on_o` bit set before the edge) has its `hdrm_low_i` bit set, the dwell has expired, and the mode is below 2x, the mode rises by exactly one step.
- R2: After any mode change outside sleep, `mode_o` keeps its new value for at least DWELL clock cycles (default 8). A continuous low-headroom demand from 1x reaches 2x exactly DWELL cycles after reaching 1.5x.
- R3: The mode falls one step only when the dwell has expired, at least one sink is on, no on-sink reports low, and every on-sink has its `hdrm_rec_i` bit set. Having no low flag alone never lowers the mode.
- R4: `sleep_o` is 1 in the cycle after `sink_en_i` is all zero. Sleep forces the mode to 1x and clears the dwell. `pump_clk_en_o` is 1 only when the mode is 1.5x or 2x and the block is neither asleep nor in a fault.
- R5: When `ovp_i` is high at an edge, `pump_clk_en_o` is 0 after that edge. Pumping resumes at the first edge where `ovp_i` is low. The mode does not change because of `ovp_i`.
- R6: When `open_det_i[i]` is high while `sink_en_i[i]` is set and there is no over-temperature, sink i is latched off (`sink_on_o[i]` = 0). The other sinks are not affected. The latch holds after `open_det_i` falls.
- R7: A latched open fault on sink i clears only at an edge where `sink_en_wr_i` is 1 and the written `sink_en_i[i]` is 0, or on an `en` reset. A write that keeps bit i at 1 leaves the fault latched.
- R8: While `otp_i` is high, `sink_on_o` is all zero and `pump_clk_en_o` is 0. The mode, the dwell count and the fault latches are kept, and outputs return to their earlier values once `otp_i` falls.
- R9: While `en` is low, all state is reset at once: `mode_o` = 0, `pump_clk_en_o` = 0, `sink_on_o` = 0, `sleep_o` = 1, and all fault latches are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pump-rate clock |
| en | input | 1 | Chip enable; low resets all state asynchronously |
| sink_en_i | input | NSINK | Software sink-enable bits |
| sink_en_wr_i | input | 1 | Pulses when software writes `sink_en_i` |
| hdrm_low_i | input | NSINK | Per-sink headroom-low comparator flags |
| hdrm_rec_i | input | NSINK | Per-sink headroom-recovered comparator flags |
| open_det_i | input | NSINK | Per-sink open-circuit flags |
| ovp_i | input | 1 | Pump output over-voltage flag |
| otp_i | input | 1 | Over-temperature flag |
| mode_o | output | 2 | Pump multiplier code |
| pump_clk_en_o | output | 1 | Pump clock gate |
| sink_on_o | output | NSINK | Effective per-sink enables |
| sleep_o | output | 1 | Sleep indicator |

## Verification
Mode selection is tested with three kinds of headroom pattern. A sustained low flag on all sinks shows the step-by-step climb and measures the dwell between steps. A pattern with neither flag set shows that releasing the low flag alone does not lower the mode. A recovered flag on every on-sink shows the step down. Random comparator traffic, mixed with sparse fault and enable changes, is then compared each cycle against a bench model. This random phase tells apart a design that weighs headroom from every software-enabled sink from one that weighs only the sinks actually driven. It also separates a fault that is latched from one that just follows its flag.

// File: rtl/cp_sup_pkg.sv
package cp_sup_pkg;
  typedef enum logic [1:0] {
    PM_1X   = 2'd0,
    PM_1P5X = 2'd1,
    PM_2X   = 2'd2
  } pmode_e;
endpackage

// File: rtl/cp_float_guard.sv
module cp_float_guard #(
  parameter int NSINK = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic [NSINK-1:0] sw_en,
  input  logic             sw_wr,
  input  logic [NSINK-1:0] open_det,
  input  logic             otp,
  output logic [NSINK-1:0] sink_on
);
  logic [NSINK-1:0] fault_q, fault_d, clr, setv, on_d;

  always_comb begin
    clr     = sw_wr ? ~sw_en : '0;
    setv    = sw_en & open_det & {NSINK{~otp}};
    fault_d = (fault_q | setv) & ~clr;
    on_d    = sw_en & ~fault_d & {NSINK{~otp}};
  end

  always_ff @(posedge clk or negedge en) begin
    if (!en) begin
      fault_q <= '0;
      sink_on <= '0;
    end else begin
      fault_q <= fault_d;
      sink_on <= on_d;
    end
  end

  for (genvar g = 0; g < NSINK; g++) begin : g_chk
    // R6: a latched sink is never driven
    p_fault_masks_r6: assert property (@(posedge clk) disable iff (!en)
      fault_q[g] |-> !sink_on[g]);
    // R7: only a write clears a latched fault
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!en)
      (fault_q[g] && !sw_wr) |=> fault_q[g]);
  end
endmodule

// File: rtl/cp_mode_fsm.sv
module cp_mode_fsm
  import cp_sup_pkg::*;
#(
  parameter int NSINK = 4,
  parameter int DWELL = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic [NSINK-1:0] sink_on,
  input  logic [NSINK-1:0] hd_low,
  input  logic [NSINK-1:0] hd_rec,
  input  logic             sleep_req,
  input  logic             otp,
  output pmode_e           mode_q,
  output pmode_e           mode_d
);
  localparam int DW_W = $clog2(DWELL + 1);
  localparam logic [DW_W-1:0] RELOAD = DW_W'(DWELL - 1);

  logic [DW_W-1:0] dwell_q, dwell_d;
  logic up, rec;

  always_comb begin
    up  = |(sink_on & hd_low);
    rec = (|sink_on) && (&(hd_rec | ~sink_on));
    mode_d  = mode_q;
    dwell_d = dwell_q;
    if (sleep_req) begin
      mode_d  = PM_1X;
      dwell_d = '0;
    end else if (otp) begin
      mode_d  = mode_q;
    end else if (dwell_q != '0) begin
      dwell_d = dwell_q - 1'b1;
    end else if (up && mode_q != PM_2X) begin
      mode_d  = pmode_e'(mode_q + 2'd1);
      dwell_d = RELOAD;
    end else if (rec && !up && mode_q != PM_1X) begin
      mode_d  = pmode_e'(mode_q - 2'd1);
      dwell_d = RELOAD;
    end
  end

  always_ff @(posedge clk or negedge en) begin
    if (!en) begin
      mode_q  <= PM_1X;
      dwell_q <= '0;
    end else begin
      mode_q  <= mode_d;
      dwell_q <= dwell_d;
    end
  end

  // R2: no change while the dwell runs (sleep excepted)
  p_dwell_hold_r2: assert property (@(posedge clk) disable iff (!en)
    (($past(dwell_q) != '0) && !$past(sleep_req)) |-> (mode_q == $past(mode_q)));
  // R3: a step down needs the recovered condition
  p_down_needs_rec_r3: assert property (@(posedge clk) disable iff (!en)
    ((mode_q < $past(mode_q)) && !$past(sleep_req)) |-> $past(rec));
  // R1: the mode never jumps two steps upward
  p_up_one_step_r1: assert property (@(posedge clk) disable iff (!en)
    (mode_q == PM_2X) |-> ($past(mode_q) != PM_1X));
endmodule

// File: rtl/cp_pump_gate.sv
module cp_pump_gate
  import cp_sup_pkg::*;
(
  input  logic   clk,
  input  logic   en,
  input  pmode_e mode_d,
  input  logic   sleep_req,
  input  logic   ovp,
  input  logic   otp,
  output logic   clk_en,
  output logic   sleep
);
  logic clk_en_d;

  always_comb clk_en_d = !sleep_req && !ovp && !otp && (mode_d != PM_1X);

  always_ff @(posedge clk or negedge en) begin
    if (!en) begin
      clk_en <= 1'b0;
      sleep  <= 1'b1;
    end else begin
      clk_en <= clk_en_d;
      sleep  <= sleep_req;
    end
  end

  // R4: asleep means no pumping
  p_sleep_no_clk_r4: assert property (@(posedge clk) disable iff (!en)
    sleep |-> !clk_en);
  // R5: over-voltage halts switching at the next edge
  p_ovp_stops_r5: assert property (@(posedge clk) disable iff (!en)
    ovp |=> !clk_en);
endmodule

// File: rtl/cp_supervisor.sv
module cp_supervisor
  import cp_sup_pkg::*;
#(
  parameter int NSINK = 4,
  parameter int DWELL = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic [NSINK-1:0] sink_en_i,
  input  logic             sink_en_wr_i,
  input  logic [NSINK-1:0] hdrm_low_i,
  input  logic [NSINK-1:0] hdrm_rec_i,
  input  logic [NSINK-1:0] open_det_i,
  input  logic             ovp_i,
  input  logic             otp_i,
  output logic [1:0]       mode_o,
  output logic             pump_clk_en_o,
  output logic [NSINK-1:0] sink_on_o,
  output logic             sleep_o
);
  logic   sleep_req;
  pmode_e mode_q, mode_d;

  assign sleep_req = (sink_en_i == '0);

  cp_float_guard #(.NSINK(NSINK)) u_guard (
    .clk(clk), .en(en), .sw_en(sink_en_i), .sw_wr(sink_en_wr_i),
    .open_det(open_det_i), .otp(otp_i), .sink_on(sink_on_o)
  );

  cp_mode_fsm #(.NSINK(NSINK), .DWELL(DWELL)) u_mode (
    .clk(clk), .en(en), .sink_on(sink_on_o), .hd_low(hdrm_low_i),
    .hd_rec(hdrm_rec_i), .sleep_req(sleep_req), .otp(otp_i),
    .mode_q(mode_q), .mode_d(mode_d)
  );

  cp_pump_gate u_gate (
    .clk(clk), .en(en), .mode_d(mode_d), .sleep_req(sleep_req),
    .ovp(ovp_i), .otp(otp_i), .clk_en(pump_clk_en_o), .sleep(sleep_o)
  );

  assign mode_o = mode_q;

  // R1: code 3 is never produced
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!en)
    mode_o != 2'd3);
  // R8: over-temperature blanks every output
  p_otp_blank_r8: assert property (@(posedge clk) disable iff (!en)
    otp_i |=> (sink_on_o == '0 && !pump_clk_en_o));
  // R4: 1x never pumps
  p_unity_idle_r4: assert property (@(posedge clk) disable iff (!en)
    (mode_o == 2'd0) |-> !pump_clk_en_o);
endmodule

// File: tb/cp_supervisor_tb.sv
module cp_supervisor_tb;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic en = 1'b0, wr = 1'b0, ovp = 1'b0, otp = 1'b0;
  logic [NS-1:0] sw = '0, low = '0, rec = '0, opn = '0;
  logic [1:0] mode_o;
  logic clk_en_o, sleep_o;
  logic [NS-1:0] sink_on_o;

  int checks = 0, errors = 0;
  int m_mode = 0, m_dwell = 0;
  logic [NS-1:0] m_fault = '0, m_on = '0;
  logic m_clk = 1'b0, m_sleep = 1'b1;

  cp_supervisor #(.NSINK(NS), .DWELL(DW)) u_dut (
    .clk(clk), .en(en), .sink_en_i(sw), .sink_en_wr_i(wr),
    .hdrm_low_i(low), .hdrm_rec_i(rec), .open_det_i(opn),
    .ovp_i(ovp), .otp_i(otp), .mode_o(mode_o),
    .pump_clk_en_o(clk_en_o), .sink_on_o(sink_on_o), .sleep_o(sleep_o)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NS-1:0] clr, setv, nf, non;
    logic up, rc, slp;
    int nm, nd;
    if (!en) begin
      m_mode = 0; m_dwell = 0; m_fault = '0; m_on = '0; m_clk = 0; m_sleep = 1;
      return;
    end
    clr  = wr ? ~sw : '0;
    setv = sw & opn & {NS{~otp}};
    nf   = (m_fault | setv) & ~clr;
    non  = sw & ~nf & {NS{~otp}};
    up   = |(m_on & low);
    rc   = (m_on != '0) && ((rec | ~m_on) == '1);
    slp  = (sw == '0);
    nm = m_mode; nd = m_dwell;
    if (slp) begin nm = 0; nd = 0; end
    else if (otp) begin end
    else if (m_dwell != 0) nd = m_dwell - 1;
    else if (up && m_mode != 2) begin nm = m_mode + 1; nd = DW - 1; end
    else if (rc && !up && m_mode != 0) begin nm = m_mode - 1; nd = DW - 1; end
    m_clk = !slp && !otp && !ovp && (nm != 0);
    m_sleep = slp; m_mode = nm; m_dwell = nd; m_fault = nf; m_on = non;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    chk("R1 mode", int'(mode_o), m_mode);
    chk("R4 pump clock", int'(clk_en_o), int'(m_clk));
    chk("R6 sink enables", int'(sink_on_o), int'(m_on));
    chk("R4 sleep", int'(sleep_o), int'(m_sleep));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int t1, t2;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R9 reset state
    repeat (3) cyc();
    chk("R9 reset mode", int'(mode_o), 0);
    chk("R9 reset sleep", int'(sleep_o), 1);
    chk("R9 reset sinks", int'(sink_on_o), 0);
    // R1/R2 climb with dwell
    en = 1; sw = '1; wr = 1; cyc(); wr = 0; low = '1;
    t1 = -1; t2 = -1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (mode_o == 2'd1 && t1 < 0) t1 = i;
      if (mode_o == 2'd2 && t2 < 0) t2 = i;
    end
    chk("R2 dwell between steps", t2 - t1, DW);
    chk("R1 reached 2x", int'(mode_o), 2);
    // R3 no drop without recovered
    low = '0; rec = '0;
    repeat (20) cyc();
    chk("R3 hold without recovered", int'(mode_o), 2);
    rec = '1; cyc(); rec = '0;
    chk("R3 step down on recovered", int'(mode_o), 1);
    // R8 over-temperature
    low = '1; repeat (30) cyc();
    otp = 1; cyc();
    chk("R8 sinks blanked", int'(sink_on_o), 0);
    chk("R8 clock off", int'(clk_en_o), 0);
    repeat (5) cyc(); otp = 0; cyc();
    chk("R8 mode kept", int'(mode_o), 2);
    chk("R8 sinks restored", int'(sink_on_o), 15);
    // R6/R7 float latch
    opn = 4'b0010; cyc(); opn = '0; cyc();
    chk("R6 single sink latched", int'(sink_on_o), 13);
    wr = 1; cyc(); wr = 0;
    chk("R7 rewrite of one keeps latch", int'(sink_on_o), 13);
    sw = 4'b1101; wr = 1; cyc(); sw = '1; cyc(); wr = 0; cyc();
    chk("R7 latch cleared by zero write", int'(sink_on_o), 15);
    // R5 over-voltage
    ovp = 1; cyc();
    chk("R5 clock stopped", int'(clk_en_o), 0);
    ovp = 0; cyc();
    chk("R5 clock resumed", int'(clk_en_o), 1);
    // R4 sleep
    sw = '0; wr = 1; cyc(); wr = 0;
    chk("R4 sleep flag", int'(sleep_o), 1);
    chk("R4 sleep forces 1x", int'(mode_o), 0);
    // R9 en reset clears latch
    sw = '1; wr = 1; opn = 4'b0001; cyc(); wr = 0; opn = '0;
    en = 0; cyc(); en = 1; cyc();
    chk("R9 latch cleared by reset", int'(sink_on_o), 15);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr = 0;
      if ($urandom_range(15) == 0) begin sw = 4'($urandom); wr = 1; end
      else if ($urandom_range(31) == 0) wr = 1;
      low = 4'($urandom) & 4'($urandom);
      rec = 4'($urandom) | 4'($urandom);
      opn = '0;
      for (int k = 0; k < NS; k++) if ($urandom_range(40) == 0) opn[k] = 1'b1;
      ovp = ($urandom_range(7) == 0);
      otp = ($urandom_range(39) == 0);
      en  = ($urandom_range(299) != 0);
      cyc();
    end
    summary();
  end
endmodule